// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Edge Interrupts

This block is one bank of sixteen general-purpose pins with a 32-bit register interface. Software reads and writes it through a select, write-enable, byte address and write data, and gets read data back in the same cycle. Every pin can be an input or an output. The pin value is sampled through a synchroniser, and an output value and an output enable go out to the pad logic.

Each pin has its own two-bit edge selector. A selected edge on the synchronised input latches a status bit. Status bits are cleared by writing ones to them. A per-pin enable decides which status bits drive the single bank interrupt line.

Output data, interrupt enable and wake enable each have separate set and clear alias addresses. A driver can change single bits with one write instead of a read-modify-write. The wake-enable bits are held and read back for use by logic outside the bank.

Top module: `gpio16_bank`

## Requirements
- R1: After reset, direction is 0xFFFF (all pins inputs), so pin_oe is 0. Output data, interrupt enable, wake enable, edge selects and status are all 0, and irq is 0.
- R2: Byte offsets are: status 0x18, interrupt enable 0x1C, wake enable 0x28, data-in 0x2C, output data 0x30, direction 0x34, edge select for pins 0-7 0x38, edge select for pins 8-15 0x3C. Writable registers read back what was written in bits 15:0 and read 0 in bits 31:16. Any offset not listed in R2, R3 or R11 reads 0 and ignores writes.
- R3: Set aliases are 0xF0 (output data), 0xDC (interrupt enable) and 0xE8 (wake enable). Clear aliases are 0xB0, 0x9C and 0xA8 for the same registers. A 1 in write-data bit n sets or clears bit n; a 0 leaves bit n unchanged.
- R4: pin_oe[n] is the inverse of direction bit n (1 = input). pin_out equals the output data register.
- R5: Data-in (0x2C) returns pin_in after a two-flop synchroniser. A pin change made before clock edge k is readable after edge k+1 and not after edge k. Writes to 0x2C are ignored.
- R6: Pin n's edge field is bits 2*(n mod 8)+1 : 2*(n mod 8) of register 0x38 for pins 0-7, or 0x3C for pins 8-15. Field bit 1 selects rising edges and field bit 0 selects falling edges. 11 selects both edges and 00 selects none.
- R7: On a selected edge, the pin's status bit sets on the clock edge after the synchronised value changes, which is the third clock edge after the pin change. This happens whether or not the pin's interrupt enable is set. Unselected edges leave status unchanged.
- R8: Writing 0x18 clears each status bit whose write-data bit is 1. Bits written as 0 are unchanged.
- R9: irq is 1 exactly when some pin has both its status bit and its interrupt-enable bit set.
- R10: If a status-clear write and a new selected edge for the same pin fall in the same cycle, the status bit stays set.
- R11: Offset 0x00 reads the major version in bits 7:4 and the minor version in bits 3:0, set by parameters. Writes to 0x00 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | 16 | Raw pin inputs |
| pin_out | output | 16 | Output data to pads |
| pin_oe | output | 16 | Output enable to pads, 1 = drive |
| irq | output | 1 | Bank interrupt |

## Verification
Two functions can hit the same status bit in one cycle: software clearing it, and the edge detector setting it. The bench creates this case by changing a pin and then timing a clear write so that it lands on the exact clock edge where the detected edge is captured. It then expects the bit to read back as 1, and expects a later clear with no edge present to drop it to 0. Random rounds of register writes, pin changes and clears are checked against a bench model of the status, enable and data registers.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
    localparam int PINS   = 16;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int EDGE_W = 2 * PINS;

    localparam logic [AW-1:0] OFS_REV      = 8'h00;
    localparam logic [AW-1:0] OFS_STAT     = 8'h18;
    localparam logic [AW-1:0] OFS_IEN      = 8'h1C;
    localparam logic [AW-1:0] OFS_WAKE     = 8'h28;
    localparam logic [AW-1:0] OFS_DIN      = 8'h2C;
    localparam logic [AW-1:0] OFS_DOUT     = 8'h30;
    localparam logic [AW-1:0] OFS_DIR      = 8'h34;
    localparam logic [AW-1:0] OFS_EDGE_LO  = 8'h38;
    localparam logic [AW-1:0] OFS_EDGE_HI  = 8'h3C;
    localparam logic [AW-1:0] OFS_IEN_CLR  = 8'h9C;
    localparam logic [AW-1:0] OFS_WAKE_CLR = 8'hA8;
    localparam logic [AW-1:0] OFS_DOUT_CLR = 8'hB0;
    localparam logic [AW-1:0] OFS_IEN_SET  = 8'hDC;
    localparam logic [AW-1:0] OFS_WAKE_SET = 8'hE8;
    localparam logic [AW-1:0] OFS_DOUT_SET = 8'hF0;

    typedef logic [PINS-1:0] pinvec_t;

    typedef struct packed {
        pinvec_t             dout;
        pinvec_t             dir;
        pinvec_t             ien;
        pinvec_t             wake;
        pinvec_t             stat;
        logic [EDGE_W-1:0]   edge_cfg;
    } bank_state_t;
endpackage

// File: rtl/gpio16_pin_sync.sv
module gpio16_pin_sync #(
    parameter int PINS   = 16,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_i,
    output logic [PINS-1:0] sync_o,
    output logic [PINS-1:0] rise_o,
    output logic [PINS-1:0] fall_o
);
    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic [STAGES-1:0] chain_d, chain_q;
        logic              prev_d, prev_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], pin_i[g]};
            prev_d  = chain_q[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= chain_d;
                prev_q  <= prev_d;
            end
        end

        assign sync_o[g] = chain_q[STAGES-1];
        assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
        assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/gpio16_edge_select.sv
module gpio16_edge_select #(
    parameter int PINS = 16
) (
    input  logic [PINS-1:0]   rise_i,
    input  logic [PINS-1:0]   fall_i,
    input  logic [2*PINS-1:0] cfg_i,
    output logic [PINS-1:0]   evt_o
);
    for (genvar g = 0; g < PINS; g++) begin : g_sel
        // field bit 1 = rising, field bit 0 = falling (R6)
        assign evt_o[g] = (rise_i[g] & cfg_i[2*g+1]) | (fall_i[g] & cfg_i[2*g]);
    end
endmodule

// File: rtl/gpio16_regs.sv
module gpio16_regs
    import gpio16_pkg::*;
#(
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  pinvec_t           din_i,
    input  pinvec_t           evt_i,
    output pinvec_t           dout_o,
    output pinvec_t           dir_o,
    output logic [EDGE_W-1:0] edge_cfg_o,
    output logic              irq_o
);
    localparam int HALF = EDGE_W / 2;

    bank_state_t state_d, state_q;
    pinvec_t     wmask;
    pinvec_t     stat_clr;
    logic        wr_en;

    always_comb begin
        state_d  = state_q;
        wr_en    = bus_sel & bus_wr;
        wmask    = bus_wdata[PINS-1:0];
        stat_clr = '0;
        if (wr_en) begin
            unique case (bus_addr)
                OFS_STAT:     stat_clr       = wmask;
                OFS_IEN:      state_d.ien    = wmask;
                OFS_IEN_SET:  state_d.ien    = state_q.ien | wmask;
                OFS_IEN_CLR:  state_d.ien    = state_q.ien & ~wmask;
                OFS_WAKE:     state_d.wake   = wmask;
                OFS_WAKE_SET: state_d.wake   = state_q.wake | wmask;
                OFS_WAKE_CLR: state_d.wake   = state_q.wake & ~wmask;
                OFS_DOUT:     state_d.dout   = wmask;
                OFS_DOUT_SET: state_d.dout   = state_q.dout | wmask;
                OFS_DOUT_CLR: state_d.dout   = state_q.dout & ~wmask;
                OFS_DIR:      state_d.dir    = wmask;
                OFS_EDGE_LO:  state_d.edge_cfg[HALF-1:0]      = bus_wdata[HALF-1:0];
                OFS_EDGE_HI:  state_d.edge_cfg[EDGE_W-1:HALF] = bus_wdata[HALF-1:0];
                default: ;
            endcase
        end
        // a new event wins over a clear in the same cycle (R10)
        state_d.stat = (state_q.stat & ~stat_clr) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.dir      <= '1;
        end else begin
            state_q          <= state_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_REV:      bus_rdata[7:0]      = {REV_MAJOR, REV_MINOR};
            OFS_STAT:     bus_rdata[PINS-1:0] = state_q.stat;
            OFS_IEN:      bus_rdata[PINS-1:0] = state_q.ien;
            OFS_WAKE:     bus_rdata[PINS-1:0] = state_q.wake;
            OFS_DIN:      bus_rdata[PINS-1:0] = din_i;
            OFS_DOUT:     bus_rdata[PINS-1:0] = state_q.dout;
            OFS_DIR:      bus_rdata[PINS-1:0] = state_q.dir;
            OFS_EDGE_LO:  bus_rdata[HALF-1:0] = state_q.edge_cfg[HALF-1:0];
            OFS_EDGE_HI:  bus_rdata[HALF-1:0] = state_q.edge_cfg[EDGE_W-1:HALF];
            default: ;
        endcase
    end

    assign dout_o     = state_q.dout;
    assign dir_o      = state_q.dir;
    assign edge_cfg_o = state_q.edge_cfg;
    assign irq_o      = |(state_q.stat & state_q.ien);

    // R1: reset values present on the first clock after reset release
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q.dir == '1 && state_q.ien == '0 && state_q.stat == '0));

    // R7: every event latches its status bit
    a_r7_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((state_q.stat & $past(evt_i)) == $past(evt_i)));

    // R8: status holds without events or clear writes
    a_r8_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && bus_addr == OFS_STAT) && evt_i == '0) |=> $stable(state_q.stat));

    // R8: cleared bits without a competing event read zero afterwards
    a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_STAT) |=>
            ((state_q.stat & $past(bus_wdata[PINS-1:0] & ~evt_i)) == '0));

    // R3: set alias only adds bits
    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_DOUT_SET) |=>
            (state_q.dout == ($past(state_q.dout) | $past(bus_wdata[PINS-1:0]))));

    // R3: clear alias only removes bits
    a_r3_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_IEN_CLR) |=>
            (state_q.ien == ($past(state_q.ien) & ~$past(bus_wdata[PINS-1:0]))));
endmodule

// File: rtl/gpio16_bank.sv
module gpio16_bank
    import gpio16_pkg::*;
#(
    parameter logic [3:0] REV_MAJOR   = 4'd2,
    parameter logic [3:0] REV_MINOR   = 4'd1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [15:0] pin_in,
    output logic [15:0] pin_out,
    output logic [15:0] pin_oe,
    output logic        irq
);
    pinvec_t           sync_v, rise_v, fall_v, evt_v, dir_v;
    logic [EDGE_W-1:0] edge_cfg;

    gpio16_pin_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .sync_o (sync_v),
        .rise_o (rise_v),
        .fall_o (fall_v)
    );

    gpio16_edge_select #(.PINS(PINS)) u_esel (
        .rise_i (rise_v),
        .fall_i (fall_v),
        .cfg_i  (edge_cfg),
        .evt_o  (evt_v)
    );

    gpio16_regs #(.REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .din_i      (sync_v),
        .evt_i      (evt_v),
        .dout_o     (pin_out),
        .dir_o      (dir_v),
        .edge_cfg_o (edge_cfg),
        .irq_o      (irq)
    );

    assign pin_oe = ~dir_v;

    // R4: a pin marked as input is never driven
    a_r4_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_v) == '0);
endmodule

// File: tb/gpio16_bank_tb.sv
`timescale 1ns/1ps
module gpio16_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] m_dout, m_dir, m_ien, m_wake, m_stat, m_pins;
    logic [31:0] m_edge;

    always #2.5 clk = ~clk;

    gpio16_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    function automatic logic [15:0] f_events(input logic [15:0] o, input logic [15:0] n,
                                             input logic [31:0] cfg);
        logic [15:0] ev = '0;
        for (int i = 0; i < 16; i++)
            ev[i] = (n[i] & ~o[i] & cfg[2*i+1]) | (~n[i] & o[i] & cfg[2*i]);
        return ev;
    endfunction

    function automatic logic [7:0] f_plain(input logic [7:0] a);
        case (a)
            8'hDC, 8'h9C: return 8'h1C;
            8'hE8, 8'hA8: return 8'h28;
            8'hF0, 8'hB0: return 8'h30;
            default:      return a;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h18: m_stat = m_stat & ~d[15:0];
            8'h1C: m_ien  = d[15:0];
            8'hDC: m_ien  = m_ien | d[15:0];
            8'h9C: m_ien  = m_ien & ~d[15:0];
            8'h28: m_wake = d[15:0];
            8'hE8: m_wake = m_wake | d[15:0];
            8'hA8: m_wake = m_wake & ~d[15:0];
            8'h30: m_dout = d[15:0];
            8'hF0: m_dout = m_dout | d[15:0];
            8'hB0: m_dout = m_dout & ~d[15:0];
            8'h34: m_dir  = d[15:0];
            8'h38: m_edge[15:0]  = d[15:0];
            8'h3C: m_edge[31:16] = d[15:0];
            default: ;
        endcase
    endtask

    function automatic logic [31:0] f_expect(input logic [7:0] a);
        case (a)
            8'h18: return {16'h0, m_stat};
            8'h1C: return {16'h0, m_ien};
            8'h28: return {16'h0, m_wake};
            8'h30: return {16'h0, m_dout};
            8'h34: return {16'h0, m_dir};
            8'h38: return {16'h0, m_edge[15:0]};
            8'h3C: return {16'h0, m_edge[31:16]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        bus_write(a, d);
        model_write(a, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  wofs [13];
        wofs = '{8'h18, 8'h1C, 8'hDC, 8'h9C, 8'h28, 8'hE8, 8'hA8,
                 8'h30, 8'hF0, 8'hB0, 8'h34, 8'h38, 8'h3C};
        void'($urandom(32'd20240611));
        m_dout = '0; m_dir = '1; m_ien = '0; m_wake = '0; m_stat = '0;
        m_edge = '0; m_pins = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h34, rd); chk("R1 direction", rd, 32'h0000FFFF);
        bus_read(8'h1C, rd); chk("R1 enable", rd, 32'h0);
        bus_read(8'h18, rd); chk("R1 status", rd, 32'h0);
        bus_read(8'h30, rd); chk("R1 dout", rd, 32'h0);
        chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R11 revision, read-only
        bus_read(8'h00, rd); chk("R11 revision", rd, 32'h00000021);
        bus_write(8'h00, 32'hFFFFFFFF);
        bus_read(8'h00, rd); chk("R11 revision after write", rd, 32'h00000021);

        // R2 unmapped offset
        bus_write(8'h10, 32'hFFFFFFFF);
        bus_read(8'h10, rd); chk("R2 unmapped", rd, 32'h0);

        // R4 direction and output data
        do_write(8'h30, 32'hFFFFA5C3);
        do_write(8'h34, 32'h0000F00F);
        chk("R4 pin_out", {16'h0, pin_out}, 32'h0000A5C3);
        chk("R4 pin_oe", {16'h0, pin_oe}, 32'h00000FF0);
        bus_read(8'h30, rd); chk("R2 dout upper bits", rd, 32'h0000A5C3);

        // R3 aliases
        do_write(8'hF0, 32'h00000018);
        bus_read(8'h30, rd); chk("R3 set alias", rd, {16'h0, m_dout});
        do_write(8'hB0, 32'h00008001);
        bus_read(8'h30, rd); chk("R3 clear alias", rd, {16'h0, m_dout});
        chk("R3 pin_out", {16'h0, pin_out}, {16'h0, m_dout});

        // R5 synchroniser latency, write to data-in ignored
        set_pins(16'h0041); m_pins = 16'h0041;
        @(negedge clk);
        bus_read(8'h2C, rd); chk("R5 din after one edge", rd, 32'h0);
        @(negedge clk);
        bus_read(8'h2C, rd); chk("R5 din after two edges", rd, 32'h00000041);
        bus_write(8'h2C, 32'h0000FFFF);
        bus_read(8'h2C, rd); chk("R5 din write ignored", rd, 32'h00000041);
        bus_read(8'h18, rd); chk("R7 no event when edges off", rd, 32'h0);

        // R6/R7 rising-only on pin 3, enable off
        do_write(8'h38, 32'h00000080);
        set_pins(16'h0049); m_pins = 16'h0049;
        @(negedge clk); @(negedge clk);
        bus_read(8'h18, rd); chk("R7 not yet latched", rd, 32'h0);
        @(negedge clk);
        bus_read(8'h18, rd); chk("R7 latched with enable off", rd, 32'h00000008);
        m_stat = 16'h0008;
        chk("R9 irq masked", {31'h0, irq}, 32'h0);
        do_write(8'hDC, 32'h00000008);
        chk("R9 irq enabled", {31'h0, irq}, 32'h1);
        bus_write(8'h18, 32'h0);
        bus_read(8'h18, rd); chk("R8 zero write no effect", rd, 32'h00000008);
        do_write(8'h18, 32'h00000008);
        bus_read(8'h18, rd); chk("R8 one clears", rd, 32'h0);
        chk("R9 irq after clear", {31'h0, irq}, 32'h0);
        set_pins(16'h0041); m_pins = 16'h0041;
        repeat (3) @(negedge clk);
        bus_read(8'h18, rd); chk("R6 falling not selected", rd, 32'h0);

        // R6 falling-only on pin 12 (high register bits 9:8)
        do_write(8'h3C, 32'h00000100);
        set_pins(16'h1041); m_pins = 16'h1041;
        repeat (3) @(negedge clk);
        bus_read(8'h18, rd); chk("R6 rising ignored pin12", rd, 32'h0);
        set_pins(16'h0041); m_pins = 16'h0041;
        repeat (3) @(negedge clk);
        bus_read(8'h18, rd); chk("R6 falling pin12", rd, 32'h00001000);
        do_write(8'h18, 32'h00001000);

        // R10 clear and new edge in the same cycle, pin 9 both edges
        do_write(8'h3C, 32'h0000010C);
        set_pins(16'h0241); m_pins = 16'h0241;
        repeat (3) @(negedge clk);
        bus_read(8'h18, rd); chk("R10 first edge", rd, 32'h00000200);
        set_pins(16'h0041); m_pins = 16'h0041;
        @(negedge clk);
        bus_write(8'h18, 32'h00000200);
        bus_read(8'h18, rd); chk("R10 edge wins over clear", rd, 32'h00000200);
        bus_write(8'h18, 32'h00000200);
        bus_read(8'h18, rd); chk("R10 later clear", rd, 32'h0);
        m_stat = '0;

        // random rounds
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 2);
            if (op == 0) begin
                logic [7:0]  a = wofs[$urandom_range(0, 12)];
                logic [31:0] d = $urandom;
                do_write(a, d);
                bus_read(f_plain(a), rd);
                chk("R2/R3 readback", rd, f_expect(f_plain(a)));
                chk("R4 pin_oe", {16'h0, pin_oe}, {16'h0, ~m_dir});
                chk("R4 pin_out", {16'h0, pin_out}, {16'h0, m_dout});
            end else if (op == 1) begin
                logic [15:0] nv = 16'($urandom);
                logic [15:0] ev;
                do_write(8'h38, $urandom);
                do_write(8'h3C, $urandom);
                ev = f_events(m_pins, nv, m_edge);
                set_pins(nv);
                repeat (3) @(negedge clk);
                m_stat = m_stat | ev;
                m_pins = nv;
                bus_read(8'h18, rd); chk("R7 random status", rd, {16'h0, m_stat});
                bus_read(8'h2C, rd); chk("R5 random din", rd, {16'h0, m_pins});
                chk("R9 random irq", {31'h0, irq}, {31'h0, |(m_stat & m_ien)});
            end else begin
                logic [31:0] d = $urandom;
                do_write(8'h18, d);
                bus_read(8'h18, rd); chk("R8 random clear", rd, {16'h0, m_stat});
                chk("R9 irq after clear", {31'h0, irq}, {31'h0, |(m_stat & m_ien)});
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule